// File: doc/BRIEF.md
# DMA Ready Flag Generator for a UART FIFO Pair

This block produces the two block-transfer handshake lines that a DMA engine watches beside a UART: a receive-ready line that asks the engine to drain the receive FIFO, and a transmit-ready line that asks it to refill the transmit FIFO. The FIFOs, the serial shifters, the baud generator and the register file live elsewhere. Their state reaches this block as fill levels, push and pop strobes, an error summary flag and a once-per-bit enable.

Receive-ready rises when the receive fill reaches a programmed trigger. It also rises when a few bytes sit in the FIFO and the serial input has stayed idle for a while. The idle limit follows the programmed character length: four bit times per character bit plus twelve. The same idle detector drives a timeout condition output. Receive-ready drops only when the FIFO runs empty or the error summary is raised. Transmit-ready works with hysteresis. It rises once enough free slots open up and falls only when the transmit FIFO is completely full.

Top module: `dma_rdy_gen`

## Requirements
- R1: While `rstN` is low, `rxReady`, `txReady` and `rxTimeout` are all 0.
- R2: When `rxLevel >= rxTrig`, the FIFO is not empty and `rxFifoErr` is 0, `rxReady` is 1 after the next rising clock edge.
- R3: `wordLen` encodes the character length as 0=5, 1=6, 2=7 and 3=8 bits. The idle limit in `bitTick` pulses is 4×length+12, which is 32, 36, 40 or 44. At the clock edge after the idle count reaches the limit with `rxLevel` nonzero, both `rxTimeout` and `rxReady` become 1. One pulse fewer leaves both at 0.
- R4: The idle count restarts from zero on any cycle in which `rxLine` is 0, `rxPush` is 1, `rxPop` is 1 or `rxLevel` is 0.
- R5: Once `rxTimeout` is 1 it holds, even with `rxLine` low, until a cycle with `rxPop` at 1 or `rxLevel` at 0. That cycle clears it at the following edge. A pop in the same cycle the limit is reached suppresses the timeout and the receive-ready set.
- R6: `rxReady` holds its value while neither a set nor a clear condition is present. It clears at the edge after `rxLevel` is 0.
- R7: `rxReady` clears at the edge after `rxFifoErr` is 1. The clear wins over a simultaneous trigger or timeout set.
- R8: `txReady` sets when the free space `DEPTH - txLevel` is at least `txTrig`. It holds when the free space is smaller. It clears when `txLevel == DEPTH`, and that clear wins.
- R9: The idle count advances only in cycles with `bitTick` at 1 and stops at the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLevel | input | LEVEL_W | Receive FIFO fill count |
| rxTrig | input | LEVEL_W | Receive trigger level |
| txLevel | input | LEVEL_W | Transmit FIFO fill count |
| txTrig | input | LEVEL_W | Transmit free-space trigger |
| wordLen | input | 2 | Character length code |
| rxLine | input | 1 | Serial receive input, high when idle |
| bitTick | input | 1 | One-cycle enable per bit time |
| rxPush | input | 1 | A byte was written into the receive FIFO |
| rxPop | input | 1 | A byte was read from the receive FIFO |
| rxFifoErr | input | 1 | Receive FIFO error summary flag |
| rxReady | output | 1 | Receive DMA request |
| txReady | output | 1 | Transmit DMA request |
| rxTimeout | output | 1 | Idle-timeout condition |

## Verification
Two collisions are provoked. First, the idle count reaches its limit in the same cycle that a pop strobe arrives. Second, the fill crosses the receive trigger while the error summary is high. For the first, the bench lets exactly the limit number of bit ticks pass, then raises `rxPop` on the cycle the limit is reached. It then expects both `rxTimeout` and `rxReady` to stay low. For the second, a vector table entry raises the level above the trigger with the error flag set and expects `rxReady` at 0. In the same entry the transmit side sees a full FIFO, where the clear also wins over the set.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;

  // Strobes from the control half to the datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } dp_ctl_t;

  // Status from the datapath back to the control half
  typedef struct packed {
    logic rxEmpty;
    logic rxAtTrig;
    logic txFull;
    logic txRoom;
    logic toHit;
  } dp_stat_t;

endpackage

// File: rtl/dma_rdy_dp.sv
module dma_rdy_dp
  import dma_rdy_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MIN_WORD = 5,
  parameter int PER_BIT  = 4,
  parameter int EXTRA    = 12,
  parameter int LEVEL_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [LEVEL_W-1:0] rxTrig,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] txTrig,
  input  logic [1:0]         wordLen,
  input  dp_ctl_t            ctl,
  output dp_stat_t           stat
);

  localparam int THR_BASE = PER_BIT * MIN_WORD + EXTRA;
  localparam int THR_MAX  = THR_BASE + PER_BIT * 3;
  localparam int CNT_W    = $clog2(THR_MAX + 1);
  localparam logic [LEVEL_W-1:0] DEPTH_V = LEVEL_W'(DEPTH);

  logic [CNT_W-1:0] idleCnt;
  logic [CNT_W-1:0] idleThr;
  logic [LEVEL_W-1:0] txFree;

  // Idle limit recomputed from the current character length
  assign idleThr = CNT_W'(THR_BASE) + CNT_W'(PER_BIT) * CNT_W'(wordLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (ctl.cntClr) begin
      idleCnt <= '0;
    end else if (ctl.cntInc && (idleCnt < idleThr)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign txFree        = DEPTH_V - txLevel;
  assign stat.rxEmpty  = (rxLevel == '0);
  assign stat.rxAtTrig = (rxLevel >= rxTrig);
  assign stat.txFull   = (txLevel >= DEPTH_V);
  assign stat.txRoom   = (txFree >= txTrig);
  assign stat.toHit    = (idleCnt >= idleThr);

  // R4: a restart strobe leaves the counter at zero
  a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntClr |=> (idleCnt == '0));

  // R9: no ticking means no movement
  a_r9_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.cntInc && !ctl.cntClr) |=> $stable(idleCnt));

  // R9: counter stops once the limit is reached
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.cntClr && stat.toHit) |=> $stable(idleCnt));

endmodule

// File: rtl/dma_rdy_ctl.sv
module dma_rdy_ctl
  import dma_rdy_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxLine,
  input  logic     bitTick,
  input  logic     rxPush,
  input  logic     rxPop,
  input  logic     rxFifoErr,
  input  dp_stat_t stat,
  output dp_ctl_t  ctl,
  output logic     rxReady,
  output logic     txReady,
  output logic     rxTimeout
);

  logic hitOk;
  logic rxClr;
  logic rxSet;
  logic toClr;

  assign ctl.cntClr = !rxLine || rxPush || rxPop || stat.rxEmpty;
  assign ctl.cntInc = bitTick;

  // A pop or empty FIFO in the hit cycle masks the timeout
  assign toClr = rxPop || stat.rxEmpty;
  assign hitOk = stat.toHit && !toClr;
  assign rxClr = stat.rxEmpty || rxFifoErr;
  assign rxSet = stat.rxAtTrig || hitOk || rxTimeout;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxTimeout <= 1'b0;
    end else if (toClr) begin
      rxTimeout <= 1'b0;
    end else if (hitOk) begin
      rxTimeout <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReady <= 1'b0;
    end else if (rxClr) begin
      rxReady <= 1'b0;
    end else if (rxSet) begin
      rxReady <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReady <= 1'b0;
    end else if (stat.txFull) begin
      txReady <= 1'b0;
    end else if (stat.txRoom) begin
      txReady <= 1'b1;
    end
  end

  // R2: trigger reached without a clear sets receive-ready
  a_r2_trig_sets: assert property (@(posedge clk) disable iff (!rstN)
    (stat.rxAtTrig && !stat.rxEmpty && !rxFifoErr) |=> rxReady);

  // R3: timeout only rises after the datapath reported the limit
  a_r3_rise_from_hit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxTimeout) |-> $past(stat.toHit));

  // R5: timeout holds without pop or empty
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxTimeout && !rxPop && !stat.rxEmpty) |=> rxTimeout);

  // R5: pop drops the timeout
  a_r5_pop_clears: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |=> !rxTimeout);

  // R6: empty FIFO drops receive-ready
  a_r6_empty_clears: assert property (@(posedge clk) disable iff (!rstN)
    stat.rxEmpty |=> !rxReady);

  // R7: error summary drops receive-ready
  a_r7_err_clears: assert property (@(posedge clk) disable iff (!rstN)
    rxFifoErr |=> !rxReady);

  // R8: full transmit FIFO drops transmit-ready
  a_r8_full_clears: assert property (@(posedge clk) disable iff (!rstN)
    stat.txFull |=> !txReady);

endmodule

// File: rtl/dma_rdy_gen.sv
module dma_rdy_gen
  import dma_rdy_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int LEVEL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [LEVEL_W-1:0] rxTrig,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] txTrig,
  input  logic [1:0]         wordLen,
  input  logic               rxLine,
  input  logic               bitTick,
  input  logic               rxPush,
  input  logic               rxPop,
  input  logic               rxFifoErr,
  output logic               rxReady,
  output logic               txReady,
  output logic               rxTimeout
);

  dp_ctl_t  dpCtl;
  dp_stat_t dpStat;

  dma_rdy_dp #(
    .DEPTH   (DEPTH),
    .LEVEL_W (LEVEL_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .rxLevel (rxLevel),
    .rxTrig  (rxTrig),
    .txLevel (txLevel),
    .txTrig  (txTrig),
    .wordLen (wordLen),
    .ctl     (dpCtl),
    .stat    (dpStat)
  );

  dma_rdy_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .bitTick   (bitTick),
    .rxPush    (rxPush),
    .rxPop     (rxPop),
    .rxFifoErr (rxFifoErr),
    .stat      (dpStat),
    .ctl       (dpCtl),
    .rxReady   (rxReady),
    .txReady   (txReady),
    .rxTimeout (rxTimeout)
  );

  // R1: outputs stay low while reset is held
  always_comb begin
    if (!rstN) begin
      a_r1_reset_low: assert (!rxReady && !txReady && !rxTimeout);
    end
  end

endmodule

// File: tb/dma_rdy_gen_tb.sv
module dma_rdy_gen_tb;

  localparam int DEPTH   = 64;
  localparam int LEVEL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN;
  logic [LEVEL_W-1:0] rxLevel, rxTrig, txLevel, txTrig;
  logic [1:0] wordLen;
  logic rxLine, bitTick, rxPush, rxPop, rxFifoErr;
  logic rxReady, txReady, rxTimeout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dma_rdy_gen #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .rxTrig(rxTrig),
    .txLevel(txLevel), .txTrig(txTrig), .wordLen(wordLen),
    .rxLine(rxLine), .bitTick(bitTick), .rxPush(rxPush), .rxPop(rxPop),
    .rxFifoErr(rxFifoErr), .rxReady(rxReady), .txReady(txReady),
    .rxTimeout(rxTimeout)
  );

  typedef struct packed {
    logic [6:0] rxL;
    logic [6:0] rxT;
    logic       err;
    logic [6:0] txL;
    logic [6:0] txT;
    logic       expRx;
    logic       expTx;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{7'd0,  7'd8, 1'b0, 7'd0,  7'd16, 1'b0, 1'b1},
    '{7'd5,  7'd8, 1'b0, 7'd50, 7'd16, 1'b0, 1'b1},
    '{7'd8,  7'd8, 1'b0, 7'd64, 7'd16, 1'b1, 1'b0},
    '{7'd3,  7'd8, 1'b0, 7'd50, 7'd16, 1'b1, 1'b0},
    '{7'd3,  7'd8, 1'b1, 7'd48, 7'd16, 1'b0, 1'b1},
    '{7'd3,  7'd8, 1'b0, 7'd60, 7'd16, 1'b0, 1'b1},
    '{7'd10, 7'd8, 1'b1, 7'd64, 7'd16, 1'b0, 1'b0},
    '{7'd10, 7'd8, 1'b0, 7'd10, 7'd16, 1'b1, 1'b1},
    '{7'd0,  7'd8, 1'b0, 7'd64, 7'd16, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1;
      @(negedge clk);
    end
    bitTick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; rxLevel = '0; rxTrig = 7'd8; txLevel = '0; txTrig = 7'd16;
    wordLen = 2'd0; rxLine = 1'b0; bitTick = 1'b0; rxPush = 1'b0;
    rxPop = 1'b0; rxFifoErr = 1'b0;
    step(3);
    chk("R1 rxReady", rxReady, 1'b0);
    chk("R1 txReady", txReady, 1'b0);
    chk("R1 rxTimeout", rxTimeout, 1'b0);
    rstN = 1'b1;

    // R2 R6 R7 R8 vector walk, rxLine held low so no timeout
    for (int v = 0; v < NV; v++) begin
      rxLevel = VEC[v].rxL; rxTrig = VEC[v].rxT; rxFifoErr = VEC[v].err;
      txLevel = VEC[v].txL; txTrig = VEC[v].txT;
      step(1);
      chk("R2/R6/R7 rxReady vec", rxReady, VEC[v].expRx);
      chk("R8 txReady vec", txReady, VEC[v].expTx);
    end
    rxFifoErr = 1'b0; txLevel = '0;

    // R3 limit 32 for code 0
    wordLen = 2'd0; rxLine = 1'b1; rxLevel = 7'd1;
    step(1);
    tick(31); step(3);
    chk("R3 below limit rxTimeout", rxTimeout, 1'b0);
    chk("R3 below limit rxReady", rxReady, 1'b0);
    tick(1); step(1);
    chk("R3 at limit rxTimeout", rxTimeout, 1'b1);
    chk("R3 at limit rxReady", rxReady, 1'b1);

    // R5 holds with line low, then pop clears timeout, R6 rxReady holds
    rxLine = 1'b0; step(3);
    chk("R5 hold rxTimeout", rxTimeout, 1'b1);
    rxPop = 1'b1; step(1); rxPop = 1'b0;
    chk("R5 pop clears rxTimeout", rxTimeout, 1'b0);
    step(2);
    chk("R6 hold rxReady", rxReady, 1'b1);
    rxLevel = '0; step(1);
    chk("R6 empty clears rxReady", rxReady, 1'b0);

    // R4 line-low restart, limit 44 for code 3
    wordLen = 2'd3; rxLine = 1'b1; rxLevel = 7'd1;
    step(1);
    tick(40);
    rxLine = 1'b0; step(1); rxLine = 1'b1;
    tick(43); step(3);
    chk("R4 line restart rxTimeout", rxTimeout, 1'b0);
    tick(1); step(1);
    chk("R4 line restart limit 44", rxTimeout, 1'b1);

    // R5 empty clears timeout
    rxLevel = '0; step(1);
    chk("R5 empty clears rxTimeout", rxTimeout, 1'b0);
    chk("R6 empty clears rxReady", rxReady, 1'b0);

    // R4 push restart, limit 40 for code 2
    wordLen = 2'd2; rxLevel = 7'd2;
    step(1);
    tick(20);
    rxPush = 1'b1; step(1); rxPush = 1'b0;
    tick(39); step(3);
    chk("R4 push restart rxTimeout", rxTimeout, 1'b0);
    tick(1); step(1);
    chk("R4 push restart limit 40", rxTimeout, 1'b1);

    // R7 error clears rxReady while timeout stays
    rxFifoErr = 1'b1; step(1);
    chk("R7 err clears rxReady", rxReady, 1'b0);
    chk("R5 err leaves rxTimeout", rxTimeout, 1'b1);
    rxLevel = '0; step(1); rxFifoErr = 1'b0;

    // R5 collision: pop in the cycle the limit (44) is reached
    wordLen = 2'd3; rxLevel = 7'd1;
    step(1);
    tick(44);
    rxPop = 1'b1; step(1); rxPop = 1'b0;
    chk("R5 pop beats hit rxTimeout", rxTimeout, 1'b0);
    chk("R5 pop beats hit rxReady", rxReady, 1'b0);

    // R9 no ticks means no timeout however long
    step(60);
    chk("R9 no tick no timeout", rxTimeout, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule